// File: doc/BRIEF.md
# Indirect Data Memory Addressing Unit

This unit sits between the core of a small 8-bit microcontroller and its data storage. It decodes every data-space access that the core makes. Two addresses in the data space are virtual and hold no storage. Each one is paired with a pointer register. An access to a virtual address is sent on to the location that its pointer holds. The unit also keeps the two pointer registers and the accumulator, which is mapped into the same space. Every other location is passed straight through to an external data RAM.

The first pointer can reach only general data memory. The second pointer can reach either data memory or a separate display memory, and a configuration input chooses which. An indirect access that resolves back onto a virtual address reads as zero, and a write to it is dropped. Reads are combinational from address to data. Writes take effect on the rising clock edge.

Top module: `indirect_mem_unit`

## Requirements
- R1: After reset, both pointer registers read 0x80 and the accumulator reads 0x00.
- R2: A read or write at address 0x00 reaches the data memory location given by the low 7 bits of the pointer at address 0x01.
- R3: When `disp_sel` is 0, a read or write at address 0x02 reaches the data memory location given by the low 7 bits of the pointer at address 0x03.
- R4: When `disp_sel` is 1, a read or write at address 0x02 reaches display memory at the low 7 bits of the pointer at 0x03, and data memory is left alone. A display location with index 0x00 or 0x02 is ordinary storage.
- R5: An indirect data-memory access whose resolved address is 0x00 or 0x02 reads 0x00, changes no state and raises no RAM strobe.
- R6: Bit 7 of each pointer always reads as 1. A write to a pointer stores only bits 6:0.
- R7: The accumulator lives at address 0x05, is held inside the unit, is shown on `acc`, and can also be reached through a pointer.
- R8: A pointer whose value resolves to 0x01 or 0x03 reads and writes that pointer register.
- R9: Read data follows the address with no clock edge. Nothing changes while `cpu_wr` is 0.
- R10: At most one backing-RAM strobe is active at a time. The display-memory strobes are active only for an access at 0x02 while `disp_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 7 | Core data-space address |
| cpu_wdata | input | 8 | Core write data |
| cpu_wr | input | 1 | Core write strobe |
| cpu_rd | input | 1 | Core read strobe |
| cpu_rdata | output | 8 | Read data to the core, 0 when not reading |
| disp_sel | input | 1 | 1 sends the second pointer to display memory |
| acc | output | 8 | Accumulator contents |
| dram_addr | output | 7 | Data RAM address |
| dram_wdata | output | 8 | Data RAM write data |
| dram_we | output | 1 | Data RAM write enable |
| dram_re | output | 1 | Data RAM read enable |
| dram_rdata | input | 8 | Data RAM asynchronous read data |
| lram_addr | output | 7 | Display RAM address |
| lram_wdata | output | 8 | Display RAM write data |
| lram_we | output | 1 | Display RAM write enable |
| lram_re | output | 1 | Display RAM read enable |
| lram_rdata | input | 8 | Display RAM asynchronous read data |

## Verification
Most internal errors in this unit are corrupted pointer or accumulator state, and the ports show them on the very next read. A pointer that is wrong shows up right away as a wrong read-back at 0x01 or 0x03, or as data that comes from the wrong RAM index. An error in the recursion check shows as a nonzero read or as a stray RAM write enable in the same cycle as the access. An error in the display-memory steering leaves data in the other RAM, so a direct read of that location in the next cycle shows it.

// File: rtl/idu_pkg.sv
package idu_pkg;

    typedef enum logic [2:0] {
        TGT_NULL = 3'd0,
        TGT_PTR0 = 3'd1,
        TGT_PTR1 = 3'd2,
        TGT_ACC  = 3'd3,
        TGT_DATA = 3'd4,
        TGT_DISP = 3'd5
    } tgt_e;

    localparam int VIRT0_LOC = 0;
    localparam int PTR0_LOC  = 1;
    localparam int VIRT1_LOC = 2;
    localparam int PTR1_LOC  = 3;
    localparam int ACC_LOC   = 5;

endpackage

// File: rtl/idu_decode.sv
module idu_decode
    import idu_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ptr0_lo,
    input  logic [ADDR_W-1:0] ptr1_lo,
    input  logic              disp_sel,
    output tgt_e              tgt,
    output logic [ADDR_W-1:0] eff
);
    localparam logic [ADDR_W-1:0] V0 = ADDR_W'(VIRT0_LOC);
    localparam logic [ADDR_W-1:0] V1 = ADDR_W'(VIRT1_LOC);
    localparam logic [ADDR_W-1:0] P0 = ADDR_W'(PTR0_LOC);
    localparam logic [ADDR_W-1:0] P1 = ADDR_W'(PTR1_LOC);
    localparam logic [ADDR_W-1:0] AC = ADDR_W'(ACC_LOC);

    logic to_disp;

    always_comb begin
        eff     = addr;
        to_disp = 1'b0;
        if (addr == V0) begin
            eff = ptr0_lo;
        end else if (addr == V1) begin
            eff     = ptr1_lo;
            to_disp = disp_sel;
        end

        if (to_disp) begin
            tgt = TGT_DISP;
        end else if (eff == V0 || eff == V1) begin
            tgt = TGT_NULL;
        end else if (eff == P0) begin
            tgt = TGT_PTR0;
        end else if (eff == P1) begin
            tgt = TGT_PTR1;
        end else if (eff == AC) begin
            tgt = TGT_ACC;
        end else begin
            tgt = TGT_DATA;
        end
    end
endmodule

// File: rtl/idu_regs.sv
module idu_regs
    import idu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ptr0_lo,
    output logic [ADDR_W-1:0] ptr1_lo,
    output logic [DATA_W-1:0] acc
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr0;
        logic [ADDR_W-1:0] ptr1;
        logic [DATA_W-1:0] acc;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (tgt)
                TGT_PTR0: st_d.ptr0 = wdata[ADDR_W-1:0];
                TGT_PTR1: st_d.ptr1 = wdata[ADDR_W-1:0];
                TGT_ACC:  st_d.acc  = wdata;
                default:  st_d      = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr0_lo = st_q.ptr0;
    assign ptr1_lo = st_q.ptr1;
    assign acc     = st_q.acc;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ptr0_lo) && $stable(ptr1_lo) && $stable(acc))); // R9
    AST_NULL_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_NULL) |=> ($stable(ptr0_lo) && $stable(ptr1_lo) && $stable(acc))); // R5
endmodule

// File: rtl/indirect_mem_unit.sv
module indirect_mem_unit
    import idu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DISP_AW = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-2:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               disp_sel,
    output logic [DATA_W-1:0]  acc,
    output logic [DATA_W-2:0]  dram_addr,
    output logic [DATA_W-1:0]  dram_wdata,
    output logic               dram_we,
    output logic               dram_re,
    input  logic [DATA_W-1:0]  dram_rdata,
    output logic [DISP_AW-1:0] lram_addr,
    output logic [DATA_W-1:0]  lram_wdata,
    output logic               lram_we,
    output logic               lram_re,
    input  logic [DATA_W-1:0]  lram_rdata
);
    localparam int ADDR_W = DATA_W - 1;

    tgt_e              tgt;
    logic [ADDR_W-1:0] eff;
    logic [ADDR_W-1:0] ptr0_lo, ptr1_lo;
    logic [DATA_W-1:0] rd_mux;
    logic              rd_only;

    idu_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (cpu_addr),
        .ptr0_lo (ptr0_lo),
        .ptr1_lo (ptr1_lo),
        .disp_sel(disp_sel),
        .tgt     (tgt),
        .eff     (eff)
    );

    idu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cpu_wr),
        .tgt    (tgt),
        .wdata  (cpu_wdata),
        .ptr0_lo(ptr0_lo),
        .ptr1_lo(ptr1_lo),
        .acc    (acc)
    );

    assign rd_only = cpu_rd && !cpu_wr;

    always_comb begin
        case (tgt)
            TGT_PTR0: rd_mux = {1'b1, ptr0_lo};
            TGT_PTR1: rd_mux = {1'b1, ptr1_lo};
            TGT_ACC:  rd_mux = acc;
            TGT_DATA: rd_mux = dram_rdata;
            TGT_DISP: rd_mux = lram_rdata;
            default:  rd_mux = '0;
        endcase
        cpu_rdata  = cpu_rd ? rd_mux : '0;
        dram_addr  = eff;
        dram_wdata = cpu_wdata;
        dram_we    = cpu_wr  && (tgt == TGT_DATA);
        dram_re    = rd_only && (tgt == TGT_DATA);
        lram_addr  = eff[DISP_AW-1:0];
        lram_wdata = cpu_wdata;
        lram_we    = cpu_wr  && (tgt == TGT_DISP);
        lram_re    = rd_only && (tgt == TGT_DISP);
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dram_we, dram_re, lram_we, lram_re})); // R10
    AST_DISP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (lram_we || lram_re) |-> (disp_sel && cpu_addr == ADDR_W'(VIRT1_LOC))); // R10
    AST_PTR_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && (cpu_addr == ADDR_W'(PTR0_LOC) || cpu_addr == ADDR_W'(PTR1_LOC)))
        |-> cpu_rdata[DATA_W-1]); // R6
    AST_NULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == ADDR_W'(VIRT0_LOC) && ptr0_lo == ADDR_W'(VIRT0_LOC))
        |-> (cpu_rdata == '0)); // R5
    AST_NULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == ADDR_W'(VIRT0_LOC) && ptr0_lo == ADDR_W'(VIRT1_LOC))
        |-> (!dram_we && !lram_we)); // R5
    AST_ACC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == ADDR_W'(ACC_LOC)) |=> (acc == $past(cpu_wdata))); // R7
endmodule

// File: tb/indirect_mem_unit_tb.sv
module indirect_mem_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, disp_sel = 1'b0;
    logic [7:0] cpu_rdata, acc;
    logic [6:0] dram_addr, lram_addr;
    logic [7:0] dram_wdata, lram_wdata, dram_rdata, lram_rdata;
    logic       dram_we, dram_re, lram_we, lram_re;

    logic [7:0] dmem [128];
    logic [7:0] lmem [128];

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    indirect_mem_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .disp_sel(disp_sel),
        .acc(acc), .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_we(dram_we),
        .dram_re(dram_re), .dram_rdata(dram_rdata), .lram_addr(lram_addr),
        .lram_wdata(lram_wdata), .lram_we(lram_we), .lram_re(lram_re),
        .lram_rdata(lram_rdata)
    );

    assign dram_rdata = dmem[dram_addr];
    assign lram_rdata = lmem[lram_addr];

    always @(posedge clk) begin
        if (dram_we) dmem[dram_addr] <= dram_wdata;
        if (lram_we) lmem[lram_addr] <= lram_wdata;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input logic s);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; disp_sel = s; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] a, input logic s, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; disp_sel = s; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #5 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    // {req, ctl(bit1 write, bit0 disp_sel), addr, wdata, expected}
    localparam int NV = 31;
    localparam logic [39:0] VEC [NV] = '{
        {8'd2, 8'h2, 8'h01, 8'h25, 8'h00},  // R2 set first pointer
        {8'd6, 8'h0, 8'h01, 8'h00, 8'hA5},  // R6 bit 7 reads 1
        {8'd2, 8'h2, 8'h00, 8'h3C, 8'h00},  // R2 indirect write
        {8'd2, 8'h0, 8'h25, 8'h00, 8'h3C},  // R2 direct view
        {8'd2, 8'h0, 8'h00, 8'h00, 8'h3C},  // R2 indirect read
        {8'd6, 8'h2, 8'h03, 8'h91, 8'h00},  // R6 bit 7 write ignored
        {8'd6, 8'h0, 8'h03, 8'h00, 8'h91},  // R6
        {8'd3, 8'h2, 8'h02, 8'h77, 8'h00},  // R3 data via second pointer
        {8'd3, 8'h0, 8'h11, 8'h00, 8'h77},  // R3
        {8'd4, 8'h3, 8'h02, 8'h5A, 8'h00},  // R4 display write
        {8'd4, 8'h1, 8'h02, 8'h00, 8'h5A},  // R4 display read
        {8'd4, 8'h0, 8'h11, 8'h00, 8'h77},  // R4 data untouched
        {8'd3, 8'h0, 8'h02, 8'h00, 8'h77},  // R3 back to data
        {8'd5, 8'h2, 8'h01, 8'h80, 8'h00},  // R5 pointer to 00
        {8'd5, 8'h2, 8'h00, 8'hEE, 8'h00},  // R5 dropped write
        {8'd5, 8'h0, 8'h00, 8'h00, 8'h00},  // R5 zero read
        {8'd5, 8'h2, 8'h03, 8'h02, 8'h00},  // R5 pointer to 02
        {8'd5, 8'h2, 8'h02, 8'h44, 8'h00},  // R5 dropped write
        {8'd5, 8'h0, 8'h02, 8'h00, 8'h00},  // R5 zero read
        {8'd4, 8'h3, 8'h02, 8'h66, 8'h00},  // R4 display index 02 is storage
        {8'd4, 8'h1, 8'h02, 8'h00, 8'h66},  // R4
        {8'd7, 8'h2, 8'h05, 8'h3B, 8'h00},  // R7 accumulator write
        {8'd7, 8'h0, 8'h05, 8'h00, 8'h3B},  // R7
        {8'd7, 8'h2, 8'h01, 8'h05, 8'h00},  // R7 pointer to accumulator
        {8'd7, 8'h0, 8'h00, 8'h00, 8'h3B},  // R7 indirect read
        {8'd7, 8'h2, 8'h00, 8'h12, 8'h00},  // R7 indirect write
        {8'd7, 8'h0, 8'h05, 8'h00, 8'h12},  // R7
        {8'd8, 8'h2, 8'h01, 8'h03, 8'h00},  // R8 pointer to pointer
        {8'd8, 8'h2, 8'h00, 8'h7F, 8'h00},  // R8 writes second pointer
        {8'd8, 8'h0, 8'h03, 8'h00, 8'hFF},  // R8
        {8'd8, 8'h0, 8'h00, 8'h00, 8'hFF}   // R8 indirect read of pointer
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        for (int i = 0; i < 128; i++) begin
            dmem[i] = 8'h00;
            lmem[i] = 8'h00;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_read(7'h01, 1'b0, r); check("R1 ptr0", r, 8'h80);
        do_read(7'h03, 1'b0, r); check("R1 ptr1", r, 8'h80);
        do_read(7'h05, 1'b0, r); check("R1 acc",  r, 8'h00);
        check("R1 acc port", acc, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[39:32], i);
            if (v[25]) begin
                do_write(v[22:16], v[15:8], v[24]);
            end else begin
                do_read(v[22:16], v[24], r);
                check(tag, r, v[7:0]);
            end
        end

        // R5 dropped writes left data locations 00 and 02 clean
        check("R5 dmem00", dmem[0], 8'h00);
        check("R5 dmem02", dmem[2], 8'h00);
        check("R7 acc port", acc, 8'h12);

        // R9 no write without cpu_wr
        @(negedge clk);
        cpu_addr = 7'h05; cpu_wdata = 8'hAA; cpu_wr = 1'b0;
        @(negedge clk);
        do_read(7'h05, 1'b0, r); check("R9 idle write", r, 8'h12);

        // R9 combinational read: address change without a clock edge
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 7'h25;
        #1 check("R9 comb read a", cpu_rdata, 8'h3C);
        cpu_addr = 7'h05;
        #1 check("R9 comb read b", cpu_rdata, 8'h12);
        cpu_rd = 1'b0;

        // R10 pointer write raises no RAM strobe; display strobe only with disp_sel
        @(negedge clk);
        cpu_addr = 7'h01; cpu_wdata = 8'h30; cpu_wr = 1'b1; disp_sel = 1'b1;
        #2 check("R10 no strobe on ptr write", {6'b0, dram_we, lram_we}, 8'h00);
        @(negedge clk);
        cpu_addr = 7'h00; cpu_wdata = 8'h9C; disp_sel = 1'b1;
        #2 check("R10 data strobe only", {6'b0, dram_we, lram_we}, 8'h02);
        @(negedge clk);
        cpu_wr = 1'b0; disp_sel = 1'b0;
        check("R2 new pointer target", dmem[7'h30], 8'h9C);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule